// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-slave SPI master that software drives through a small bank of 32-bit registers. Software chooses the clock polarity and phase, an 8-bit or 16-bit word length and a serial clock divisor. It drives the one chip-select line directly. Writing a word to the transmit register sends it out on MOSI, most significant bit first, while MISO is shifted in at the same time. When the last clock edge has gone by, a completion flag is set and the received word can be read back, right-aligned.

The bus is a plain read/write port. Writes take effect at the clock edge on which `bus_wr` is high. A read returns registered data on `bus_rdata` in the cycle after `bus_rd` is high. Register selection uses byte address bits [4:2]. The clock polarity, phase, word length and divisor are copied when a transfer starts, so configuration writes made during a transfer apply only to the next one.

Top module: `spi_regbus_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and the status, configuration and control registers all read 0.
- R2: Control register (offset 0x00) bit 0 set to 1 drives `spi_cs_n` low in the cycle after the write, and bit 0 set to 0 drives it high. Bit 0 reads back as written.
- R3: The configuration register (offset 0x04) stores bits [4:0] (divider code), bit 5 (1 = 16-bit words), bit 11 (clock polarity) and bit 12 (clock phase). All other bits read 0.
- R4: A write to the transmit register (offset 0x08) while idle starts a transfer. Status (offset 0x10) bit 1 reads 1 while it runs. The transfer makes exactly 2×W clock edges, where W is the word length. When it ends, status bit 0 becomes 1.
- R5: MOSI carries the transmit word most significant bit first. In 8-bit mode the low byte of the written value is used.
- R6: MISO bits are shifted in most significant bit first. The receive register (offset 0x0C) then returns the word right-aligned, with zeros above bit W-1.
- R7: When idle, `spi_sclk` rests at the polarity bit. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: With divider code bit 4 set and code[3:0] ≥ 2, every serial clock half period lasts code[3:0] system clocks. This gives a divisor of 2×code[3:0], that is, an even value from 4 to 30.
- R9: A divider code with bit 4 clear, or with code[3:0] below 2, gives half periods of 2 system clocks (divide by 4).
- R10: A transmit write while a transfer is in progress is ignored. The running word completes unchanged and no further transfer starts.
- R11: Writing the status register with bit 0 clear clears the completion flag. A write with bit 0 set leaves it unchanged.
- R12: In 16-bit mode, the 16-bit word is sent and received in its natural bit order, with no byte swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions run on every cycle and check the following:
- chip select follows each control write;
- a transfer only ever begins on a transmit write;
- MOSI holds still between divider ticks;
- the completion flag is raised after a finished transfer, and a clearing write drops it;
- the idle clock tracks the polarity setting.

Other behaviour shows only in the bench scenarios, which use a slave model that knows the phase setting. These cover bit ordering on both lines, the edge count, the measured half-period length for normal and clamped divider codes, the ignored second transmit write and the 16-bit word order.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned HALF_W = 4;

  typedef enum logic [2:0] {
    RSEL_CTRL = 3'd0,
    RSEL_CFG  = 3'd1,
    RSEL_TX   = 3'd2,
    RSEL_RX   = 3'd3,
    RSEL_STAT = 3'd4
  } rsel_e;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic       wide;
    logic [4:0] code;
  } xfer_cfg_t;

  // Half-period length in system clocks; illegal codes fall back to 2.
  function automatic logic [HALF_W-1:0] half_len(input logic [4:0] code);
    if (code[4] && (code[3:0] >= 4'd2)) return code[3:0];
    return HALF_W'(2);
  endfunction

endpackage

// File: rtl/spi_rb_clkdiv.sv
module spi_rb_clkdiv #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
  import spi_rb_pkg::*;
#(
  parameter int unsigned WMAX = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  xfer_cfg_t            cfg,
  input  logic [WMAX-1:0]      tx_word,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 fin,
  output logic                 sclk,
  output logic                 mosi,
  output logic [WMAX-1:0]      rx_word,
  output logic [HALF_W-1:0]    half
);

  localparam int unsigned WMIN = WMAX / 2;
  localparam int unsigned EW   = $clog2(2 * WMAX);

  xfer_cfg_t       cur;
  logic [EW-1:0]   edge_idx;
  logic [WMAX-1:0] sh;
  logic [WMAX-1:0] load_val;
  logic [EW-1:0]   last_edge;
  logic            leading, launch, sample;

  assign half      = half_len(cur.code);
  assign load_val  = cfg.wide ? tx_word : {tx_word[WMIN-1:0], {WMIN{1'b0}}};
  assign last_edge = cur.wide ? EW'(2 * WMAX - 1) : EW'(2 * WMIN - 1);
  assign leading   = ~edge_idx[0];
  assign launch    = tick && (cur.cpha ? leading : !leading);
  assign sample    = tick && (cur.cpha ? !leading : leading);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      busy     <= 1'b0;
      fin      <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      sh       <= '0;
      rx_word  <= '0;
      edge_idx <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        sclk <= cfg.cpol;
        if (start) begin
          busy     <= 1'b1;
          cur      <= cfg;
          edge_idx <= '0;
          rx_word  <= '0;
          if (cfg.cpha) begin
            mosi <= 1'b0;
            sh   <= load_val;
          end else begin
            mosi <= load_val[WMAX-1];
            sh   <= {load_val[WMAX-2:0], 1'b0};
          end
        end
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_idx <= edge_idx + 1'b1;
        if (sample) rx_word <= {rx_word[WMAX-2:0], miso};
        if (launch) begin
          mosi <= sh[WMAX-1];
          sh   <= {sh[WMAX-2:0], 1'b0};
        end
        if (edge_idx == last_edge) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_regbus_master.sv
module spi_regbus_master
  import spi_rb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WMAX   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              hit_ctrl, hit_cfg, hit_tx, hit_rx, hit_stat;
  xfer_cfg_t         cfg_q;
  logic              done_q;
  logic              busy_w, fin_w, tick_w, start_w;
  logic [WMAX-1:0]   rx_w;
  logic [HALF_W-1:0] half_w;
  logic              unused_bits;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign hit_ctrl = (word_idx == IDX_W'(RSEL_CTRL));
  assign hit_cfg  = (word_idx == IDX_W'(RSEL_CFG));
  assign hit_tx   = (word_idx == IDX_W'(RSEL_TX));
  assign hit_rx   = (word_idx == IDX_W'(RSEL_RX));
  assign hit_stat = (word_idx == IDX_W'(RSEL_STAT));
  assign start_w  = bus_wr && hit_tx && !busy_w;
  assign unused_bits = ^{bus_wdata[31:13], bus_wdata[10:6], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_cs_n <= 1'b1;
      cfg_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (bus_wr && hit_ctrl) spi_cs_n <= ~bus_wdata[0];
      if (bus_wr && hit_cfg)
        cfg_q <= '{cpha: bus_wdata[12], cpol: bus_wdata[11],
                   wide: bus_wdata[5], code: bus_wdata[4:0]};
      if (fin_w) done_q <= 1'b1;
      else if (bus_wr && hit_stat && !bus_wdata[0]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (hit_ctrl) bus_rdata[0] <= ~spi_cs_n;
      if (hit_cfg) begin
        bus_rdata[4:0] <= cfg_q.code;
        bus_rdata[5]   <= cfg_q.wide;
        bus_rdata[11]  <= cfg_q.cpol;
        bus_rdata[12]  <= cfg_q.cpha;
      end
      if (hit_rx) bus_rdata[WMAX-1:0] <= rx_w;
      if (hit_stat) bus_rdata[1:0] <= {busy_w, done_q};
    end
  end

  spi_rb_clkdiv #(.CNT_W(HALF_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_w),
    .half (half_w),
    .tick (tick_w)
  );

  spi_rb_shifter #(.WMAX(WMAX)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (start_w),
    .cfg     (cfg_q),
    .tx_word (bus_wdata[WMAX-1:0]),
    .tick    (tick_w),
    .miso    (spi_miso),
    .busy    (busy_w),
    .fin     (fin_w),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_word (rx_w),
    .half    (half_w)
  );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              busy,
  input logic              tick,
  input logic              fin,
  input logic              done_flag,
  input logic              cpol_cfg
);

  logic [ADDR_W-3:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  assert_cs_reset_R1: assert property (@(posedge clk)
    rst |=> spi_cs_n);

  assert_cs_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 0) |=> (spi_cs_n == !$past(bus_wdata[0])));

  assert_start_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && idx == 2));

  assert_done_set_R4: assert property (@(posedge clk) disable iff (rst)
    fin |=> done_flag);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(spi_mosi));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(cpol_cfg)) |-> (spi_sclk == cpol_cfg));

  assert_done_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 4 && !bus_wdata[0] && !fin) |=> !done_flag);

endmodule

bind spi_regbus_master spi_rb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .busy      (busy_w),
  .tick      (tick_w),
  .fin       (fin_w),
  .done_flag (done_q),
  .cpol_cfg  (cfg_q.cpol)
);

// File: tb/sim_spi_regbus_master.sv
module sim_spi_regbus_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  // slave model state
  bit          m_cpol, m_cpha;
  int          m_w = 8;
  logic [15:0] s_word = '0;
  logic [15:0] cap = '0;
  int          k = 0, edges = 0, cyc = 0, last_cyc = 0, gmin = 0, gmax = 0;
  logic        prev_sclk = 1'b0;

  always #4 clk = ~clk;

  spi_regbus_master u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always_comb begin
    int idx;
    idx = m_cpha ? (m_w - k) : (m_w - 1 - k);
    spi_miso = (idx >= 0 && idx < m_w) ? s_word[idx] : 1'b0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_sclk <= spi_sclk;
    if (spi_sclk !== prev_sclk) begin
      bit lead;
      lead = (spi_sclk != m_cpol);
      if (edges > 0) begin
        if (gmin == 0 || cyc - last_cyc < gmin) gmin <= cyc - last_cyc;
        if (cyc - last_cyc > gmax) gmax <= cyc - last_cyc;
      end
      last_cyc <= cyc;
      edges <= edges + 1;
      if (m_cpha ? !lead : lead) cap <= {cap[14:0], spi_mosi};
      if (m_cpha ? lead : !lead) k <= k + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic mon_clear(input bit cpol, input bit cpha, input int w, input logic [15:0] sw);
    repeat (3) @(negedge clk);
    m_cpol = cpol; m_cpha = cpha; m_w = w; s_word = sw;
    k = 0; edges = 0; gmin = 0; gmax = 0; cap = '0;
  endtask

  task automatic wait_done(output logic [31:0] st);
    for (int i = 0; i < 400; i++) begin
      rd(5'h10, st);
      if (st[0]) break;
    end
  endtask

  // one full transfer with a given mode, width and divider code
  task automatic t_xfer(input bit cpol, input bit cpha, input bit wide, input logic [4:0] code,
                        input logic [15:0] tx, input logic [15:0] sw, input string tag);
    logic [31:0] st, rx;
    int w, h;
    logic [15:0] mask;
    w = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    h = (code[4] && code[3:0] >= 2) ? int'(code[3:0]) : 2;
    wr(5'h04, {19'b0, cpha, cpol, 5'b0, wide, code});
    wr(5'h00, 32'h1);
    mon_clear(cpol, cpha, w, sw);
    wr(5'h08, {16'h0, tx});
    rd(5'h10, st);
    check(st[1] == 1'b1, {tag, " R4 busy"}, st, 2);
    wait_done(st);
    check(st[1:0] == 2'b01, {tag, " R4 done"}, st, 1);
    check(edges == 2 * w, {tag, " R4 edges"}, edges, 2 * w);
    check((cap & mask) == (tx & mask), {tag, " R5 mosi"}, cap & mask, tx & mask);
    rd(5'h0C, rx);
    check(rx == {16'h0, sw & mask}, {tag, " R6 rx"}, rx, sw & mask);
    check(spi_sclk == cpol, {tag, " R7 idle"}, spi_sclk, cpol);
    check(gmin == h && gmax == h, {tag, " R8 half"}, gmax, h);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    rd(5'h10, d); check(d == 0, "R1 status", d, 0);
    rd(5'h04, d); check(d == 0, "R1 cfg", d, 0);
    rd(5'h00, d); check(d == 0, "R1 ctrl", d, 0);
  endtask

  task automatic t_cs;
    logic [31:0] d;
    wr(5'h00, 32'h1);
    check(spi_cs_n == 1'b0, "R2 assert", spi_cs_n, 0);
    rd(5'h00, d); check(d == 1, "R2 readback", d, 1);
    wr(5'h00, 32'h0);
    check(spi_cs_n == 1'b1, "R2 release", spi_cs_n, 1);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); check(d == 32'h183F, "R3 fields", d, 32'h183F);
    wr(5'h04, 32'h0);
    rd(5'h04, d); check(d == 0, "R3 zero", d, 0);
  endtask

  task automatic t_status_clear;
    logic [31:0] st;
    wr(5'h04, 32'h12);
    mon_clear(0, 0, 8, 16'h55);
    wr(5'h08, 32'h0F);
    wait_done(st);
    wr(5'h10, 32'h1);
    rd(5'h10, st); check(st[0] == 1'b1, "R11 keep", st, 1);
    wr(5'h10, 32'h0);
    rd(5'h10, st); check(st[0] == 1'b0, "R11 clear", st, 0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] st;
    wr(5'h04, 32'h14);
    mon_clear(0, 0, 8, 16'h00);
    wr(5'h08, 32'h81);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'h7E);
    wait_done(st);
    repeat (20) @(negedge clk);
    check(cap[7:0] == 8'h81, "R10 word kept", cap[7:0], 8'h81);
    check(edges == 16, "R10 no restart", edges, 16);
    rd(5'h10, st); check(st[1] == 1'b0, "R10 idle", st, 0);
    wr(5'h10, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cs();
    t_cfg();
    t_xfer(0, 0, 0, 5'h12, 16'h00A5, 16'h003C, "mode0");
    t_xfer(0, 1, 0, 5'h13, 16'h00C3, 16'h0096, "mode1");
    t_xfer(1, 0, 0, 5'h1E, 16'h005A, 16'h00E1, "mode2");
    t_xfer(1, 1, 0, 5'h1F, 16'h0071, 16'h008E, "mode3");
    t_xfer(0, 0, 1, 5'h15, 16'h1234, 16'hBEEF, "R12 wide0");
    t_xfer(1, 1, 1, 5'h12, 16'hA0C1, 16'h5F03, "R12 wide3");
    t_xfer(0, 0, 0, 5'h05, 16'h00B4, 16'h0069, "R9 clamp_lowtop");
    t_xfer(0, 1, 0, 5'h11, 16'h00D2, 16'h002D, "R9 clamp_small");
    t_status_clear();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule